// File: doc/BRIEF.md
# Graphics Unit Control Port and Status Register

This block is the control side of a memory-mapped graphics engine. A CPU reaches it through a small register window with a read strobe and a write strobe. A write to the data offset is handed on to the drawing engine as a one-cycle word strobe. A write to the control offset is decoded here as a control command. The top byte of the word is the opcode and the low 24 bits are the argument.

The block keeps a 32-bit status word. That word carries the display mode, the display-off flag, an interrupt flag, the DMA direction, and three readiness flags. The readiness flags come from the transfer state that the drawing engine reports. From the direction and those flags the block drives a single DMA request line. Info-query commands pack the drawing-area corners, the drawing offset or the texture-window value into a readback latch. The CPU can then read that latch at the data offset. Reset, queue flush and interrupt acknowledge are also control commands.

Top module: `gfx_ctrl_port`

## Requirements
- R1: After reset the status word reads 0x14802000 with bit 20 replaced by `region_pal`. The readback latch reads 0, `dma_req` is 0 and `queue_flush` is 0.
- R2: A read strobe returns data on `reg_rdata` in the cycle after the strobe. Offset 0x0 returns the readback latch, offset 0x4 returns the status word, and any other offset returns 0xFFFFFFFF.
- R3: A write to offset 0x0 raises `draw_wr` for one cycle with the word on `draw_wdata`, and the status word is left unchanged.
- R4: Control opcode 0x00 restores every status field to its reset value, with bit 20 sampled again from `region_pal`. It sets the direction to off, which drops `dma_req`, and it raises `queue_flush` for one cycle. The readback latch keeps its value.
- R5: Control opcode 0x01 raises `queue_flush` for one cycle and leaves the status word unchanged.
- R6: `irq_raise` sets status bit 24 and control opcode 0x02 clears it. When both occur in the same cycle the bit ends up set.
- R7: Control opcode 0x03 copies argument bit 0 into status bit 23, which is the display-off flag.
- R8: Control opcode 0x04 writes argument bits 1:0 into status bits 30:29 as the DMA direction. The request is computed as follows:
  - direction 0 gives a request of 0;
  - direction 1 gives a request of 1;
  - direction 2 gives the ready-for-DMA flag;
  - direction 3 gives the ready-to-send flag.
  The request appears on `dma_req` and on status bit 25, and both update at the clock edge that takes the write.
- R9: Control opcode 0x08 maps its argument into the status word as follows:
  - bits 1:0 go to status bits 18:17;
  - bit 2 goes to status bit 19;
  - bit 3 (PAL) goes to status bit 20;
  - bit 4 goes to status bit 21;
  - bit 5 goes to status bit 22;
  - bit 6 goes to status bit 16;
  - bit 7 goes to status bit 14.
- R10: `xfer_state` uses 0 for idle, 1 or 3 for busy, and 2 for reading VRAM. The status flags are:
  - status bit 26 (ready for command) is 1 only when idle;
  - status bit 27 (ready to send) is 1 only when reading VRAM;
  - status bit 28 (ready for DMA) is 1 when idle, or when not reading VRAM while `cmd_collecting` is 1.
  All three flags are registered one cycle behind their inputs.
- R11: Control opcodes 0x10 to 0x1F are info queries. The subcommand is argument bits 2:0, and it loads the readback latch as follows:
  - subcommand 2 loads the zero-extended texture window;
  - subcommand 3 loads {top[9:0] at 19:10, left[9:0] at 9:0};
  - subcommand 4 loads {bottom at 19:10, right at 9:0};
  - subcommand 5 loads {y offset[10:0] at 21:11, x offset[10:0] at 10:0};
  - subcommands 0, 1, 6 and 7 leave the latch unchanged.
- R12: When the write and read strobes are both high in one cycle, the write takes effect and `reg_rdata` keeps its previous value.
- R13: Control opcodes other than 0x00 to 0x04, 0x08 and 0x10 to 0x1F change neither the status word nor the readback latch, and they raise no `queue_flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| region_pal | input | 1 | PAL value loaded into the status word on any reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| draw_wr | output | 1 | One-cycle strobe for a word to the drawing port |
| draw_wdata | output | 32 | Word forwarded to the drawing port |
| xfer_state | input | 2 | Transfer state: 0 idle, 1/3 busy, 2 reading VRAM |
| cmd_collecting | input | 1 | A drawing command is still gathering argument words |
| irq_raise | input | 1 | Sets the interrupt flag |
| area_left | input | COORD_W | Drawing area left edge |
| area_top | input | COORD_W | Drawing area top edge |
| area_right | input | COORD_W | Drawing area right edge |
| area_bottom | input | COORD_W | Drawing area bottom edge |
| ofs_x | input | OFS_W | Drawing offset X |
| ofs_y | input | OFS_W | Drawing offset Y |
| tex_window | input | TWIN_W | Texture window setting |
| dma_req | output | 1 | DMA request |
| queue_flush | output | 1 | One-cycle request to empty the drawing command queue |

## Verification
Two cases are hard to reach from the ports.

The first is a control write and a read strobe landing in the same cycle. The bench produces it by raising both strobes together after a read whose result it already knows. It then checks both that the write took effect and that `reg_rdata` kept the earlier result.

The second is the DMA request following the transfer state while the direction stays fixed. The bench holds a direction and steps `xfer_state` and `cmd_collecting` through idle, busy-collecting, busy-not-collecting and reading VRAM. It samples `dma_req` one cycle after each step.

// File: rtl/gfx_ctrl_pkg.sv
// Package: shared encodings for the graphics control port.
// Assumes a 32-bit register window; bit positions follow the status layout
// that software decodes.
package gfx_ctrl_pkg;

    typedef enum logic [1:0] {
        XF_IDLE    = 2'd0,
        XF_BUSY    = 2'd1,
        XF_VRAM_RD = 2'd2,
        XF_BUSY2   = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        DIR_OFF    = 2'd0,
        DIR_FIFO   = 2'd1,
        DIR_TO_GPU = 2'd2,
        DIR_TO_CPU = 2'd3
    } dma_dir_e;

    // Decoded control command, at most one bit set per write
    typedef struct packed {
        logic soft_rst;
        logic flush;
        logic irq_ack;
        logic disp_set;
        logic dir_set;
        logic mode_set;
        logic info;
    } ctl_cmd_t;

    localparam logic [31:0] STAT_RESET = 32'h1480_2000;
    localparam logic [31:0] STAT_FIXED = 32'h0000_2000;

    localparam int SB_REVERSE = 14;
    localparam int SB_HRES2   = 16;
    localparam int SB_HRES1   = 17;
    localparam int SB_VRES    = 19;
    localparam int SB_PAL     = 20;
    localparam int SB_DEPTH   = 21;
    localparam int SB_ILACE   = 22;
    localparam int SB_DISPOFF = 23;
    localparam int SB_IRQ     = 24;
    localparam int SB_DMAREQ  = 25;
    localparam int SB_RDYCMD  = 26;
    localparam int SB_RDYSEND = 27;
    localparam int SB_RDYDMA  = 28;
    localparam int SB_DIR     = 29;

endpackage

// File: rtl/gfx_cmd_decode.sv
// Module: gfx_cmd_decode
// Turns the opcode of a control word into a one-hot command struct.
// Assumes 'valid' is already qualified by the write strobe and control offset.
module gfx_cmd_decode
    import gfx_ctrl_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] opcode,
    output ctl_cmd_t   cmd
);

    // Opcode decode; unlisted opcodes decode to no command
    always_comb begin
        cmd = '0;
        if (valid) begin
            case (opcode)
                8'h00:   cmd.soft_rst = 1'b1;
                8'h01:   cmd.flush    = 1'b1;
                8'h02:   cmd.irq_ack  = 1'b1;
                8'h03:   cmd.disp_set = 1'b1;
                8'h04:   cmd.dir_set  = 1'b1;
                8'h08:   cmd.mode_set = 1'b1;
                default: cmd.info     = (opcode[7:4] == 4'h1);
            endcase
        end
    end

endmodule

// File: rtl/gfx_ready_track.sv
// Module: gfx_ready_track
// Registers the readiness flags from the transfer state and selects the DMA
// request using the direction that takes effect at the same edge.
// Assumes xfer_state and cmd_collecting are synchronous to clk.
module gfx_ready_track
    import gfx_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] xfer_state,
    input  logic       cmd_collecting,
    input  dma_dir_e   dir_nxt,
    output logic       rdy_cmd,
    output logic       rdy_send,
    output logic       rdy_dma,
    output logic       dma_req
);

    xfer_e st;
    logic  c_cmd, c_send, c_dma, c_req;

    // Combinational readiness from the current transfer state
    always_comb begin
        st     = xfer_e'(xfer_state);
        c_cmd  = (st == XF_IDLE);
        c_send = (st == XF_VRAM_RD);
        c_dma  = c_cmd || (!c_send && cmd_collecting);
        case (dir_nxt)
            DIR_OFF:    c_req = 1'b0;
            DIR_FIFO:   c_req = 1'b1;
            DIR_TO_GPU: c_req = c_dma;
            default:    c_req = c_send;
        endcase
    end

    // Flag and request registers; reset assumes an idle engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_cmd  <= 1'b1;
            rdy_send <= 1'b0;
            rdy_dma  <= 1'b1;
            dma_req  <= 1'b0;
        end else begin
            rdy_cmd  <= c_cmd;
            rdy_send <= c_send;
            rdy_dma  <= c_dma;
            dma_req  <= c_req;
        end
    end

    AST_RDY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_cmd && rdy_send)); // R10
    AST_CMD_GIVES_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_cmd |-> rdy_dma); // R10
    AST_SEND_BLOCKS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_send |-> !rdy_dma); // R10

endmodule

// File: rtl/gfx_info_latch.sv
// Module: gfx_info_latch
// Readback latch loaded by info-query subcommands with packed fields.
// Assumes 2*COORD_W, 2*OFS_W and TWIN_W all fit in 32 bits.
module gfx_info_latch #(
    parameter int COORD_W = 10,
    parameter int OFS_W   = 11,
    parameter int TWIN_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2:0]         sub,
    input  logic [COORD_W-1:0] area_left,
    input  logic [COORD_W-1:0] area_top,
    input  logic [COORD_W-1:0] area_right,
    input  logic [COORD_W-1:0] area_bottom,
    input  logic [OFS_W-1:0]   ofs_x,
    input  logic [OFS_W-1:0]   ofs_y,
    input  logic [TWIN_W-1:0]  tex_window,
    output logic [31:0]        latch
);

    localparam int PAD_AREA = 32 - 2 * COORD_W;
    localparam int PAD_OFS  = 32 - 2 * OFS_W;
    localparam int PAD_TWIN = 32 - TWIN_W;

    // Latch update; subcommands without a field keep the old word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= '0;
        end else if (load) begin
            case (sub)
                3'd2: latch <= {{PAD_TWIN{1'b0}}, tex_window};
                3'd3: latch <= {{PAD_AREA{1'b0}}, area_top, area_left};
                3'd4: latch <= {{PAD_AREA{1'b0}}, area_bottom, area_right};
                3'd5: latch <= {{PAD_OFS{1'b0}}, ofs_y, ofs_x};
                default: ;
            endcase
        end
    end

    AST_INFO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (sub[2:1] == 2'b00 || sub[2:1] == 2'b11)) |=> $stable(latch)); // R11

endmodule

// File: rtl/gfx_ctrl_port.sv
// Module: gfx_ctrl_port
// Register window of the graphics control side: decodes control commands,
// holds the status word, forwards drawing-port words and drives DMA request.
// Assumes one register access per cycle; a write wins over a same-cycle read.
module gfx_ctrl_port
    import gfx_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int COORD_W = 10,
    parameter int OFS_W   = 11,
    parameter int TWIN_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               region_pal,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               draw_wr,
    output logic [31:0]        draw_wdata,
    input  logic [1:0]         xfer_state,
    input  logic               cmd_collecting,
    input  logic               irq_raise,
    input  logic [COORD_W-1:0] area_left,
    input  logic [COORD_W-1:0] area_top,
    input  logic [COORD_W-1:0] area_right,
    input  logic [COORD_W-1:0] area_bottom,
    input  logic [OFS_W-1:0]   ofs_x,
    input  logic [OFS_W-1:0]   ofs_y,
    input  logic [TWIN_W-1:0]  tex_window,
    output logic               dma_req,
    output logic               queue_flush
);

    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);

    logic        ctl_wr, data_wr;
    ctl_cmd_t    cmd;
    logic [7:0]  mode_q;
    logic        dispoff_q, irq_q;
    dma_dir_e    dir_q, dir_nxt;
    logic        rdy_cmd, rdy_send, rdy_dma;
    logic [31:0] latch, status;

    assign ctl_wr  = reg_wr && (reg_addr == OFS_CTRL);
    assign data_wr = reg_wr && (reg_addr == OFS_DATA);

    gfx_cmd_decode u_dec (
        .valid  (ctl_wr),
        .opcode (reg_wdata[31:24]),
        .cmd    (cmd)
    );

    // Direction taking effect at this edge; reset forces it off
    always_comb begin
        dir_nxt = dir_q;
        if (cmd.soft_rst)     dir_nxt = DIR_OFF;
        else if (cmd.dir_set) dir_nxt = dma_dir_e'(reg_wdata[1:0]);
    end

    gfx_ready_track u_rdy (
        .clk            (clk),
        .rst_n          (rst_n),
        .xfer_state     (xfer_state),
        .cmd_collecting (cmd_collecting),
        .dir_nxt        (dir_nxt),
        .rdy_cmd        (rdy_cmd),
        .rdy_send       (rdy_send),
        .rdy_dma        (rdy_dma),
        .dma_req        (dma_req)
    );

    gfx_info_latch #(.COORD_W(COORD_W), .OFS_W(OFS_W), .TWIN_W(TWIN_W)) u_info (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cmd.info),
        .sub         (reg_wdata[2:0]),
        .area_left   (area_left),
        .area_top    (area_top),
        .area_right  (area_right),
        .area_bottom (area_bottom),
        .ofs_x       (ofs_x),
        .ofs_y       (ofs_y),
        .tex_window  (tex_window),
        .latch       (latch)
    );

    // Display fields, interrupt flag and direction held by control commands
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.soft_rst) begin
            mode_q    <= {4'b0000, region_pal, 3'b000};
            dispoff_q <= STAT_RESET[SB_DISPOFF];
            irq_q     <= irq_raise;
        end else begin
            if (cmd.mode_set) mode_q    <= reg_wdata[7:0];
            if (cmd.disp_set) dispoff_q <= reg_wdata[0];
            if (irq_raise)        irq_q <= 1'b1;
            else if (cmd.irq_ack) irq_q <= 1'b0;
        end
        if (!rst_n) dir_q <= DIR_OFF;
        else        dir_q <= dir_nxt;
    end

    // Status word assembly in the layout software decodes
    always_comb begin
        status              = STAT_FIXED;
        status[SB_REVERSE]  = mode_q[7];
        status[SB_HRES2]    = mode_q[6];
        status[SB_HRES1+:2] = mode_q[1:0];
        status[SB_VRES]     = mode_q[2];
        status[SB_PAL]      = mode_q[3];
        status[SB_DEPTH]    = mode_q[4];
        status[SB_ILACE]    = mode_q[5];
        status[SB_DISPOFF]  = dispoff_q;
        status[SB_IRQ]      = irq_q;
        status[SB_DMAREQ]   = dma_req;
        status[SB_RDYCMD]   = rdy_cmd;
        status[SB_RDYSEND]  = rdy_send;
        status[SB_RDYDMA]   = rdy_dma;
        status[SB_DIR+:2]   = dir_q;
    end

    // Registered read port; a same-cycle write suppresses the read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd && !reg_wr) begin
            if (reg_addr == OFS_DATA)      reg_rdata <= latch;
            else if (reg_addr == OFS_CTRL) reg_rdata <= status;
            else                           reg_rdata <= 32'hFFFF_FFFF;
        end
    end

    // Drawing-port forward and queue flush pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draw_wr     <= 1'b0;
            draw_wdata  <= '0;
            queue_flush <= 1'b0;
        end else begin
            draw_wr     <= data_wr;
            if (data_wr) draw_wdata <= reg_wdata;
            queue_flush <= cmd.soft_rst || cmd.flush;
        end
    end

    AST_WR_OVER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_rd) |=> $stable(reg_rdata)); // R12
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.irq_ack && !irq_raise) |=> !status[SB_IRQ]); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |=> status[SB_IRQ]); // R6
    AST_DIR_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == DIR_OFF) |-> !dma_req); // R8
    AST_DIR_FIFO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == DIR_FIFO) |-> dma_req); // R8
    AST_DIR_GPU_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == DIR_TO_GPU) |-> (dma_req == rdy_dma)); // R8
    AST_DIR_CPU_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q == DIR_TO_CPU) |-> (dma_req == rdy_send)); // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.soft_rst |=> (!dma_req && queue_flush && status[SB_DISPOFF])); // R4
    AST_DRAW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> draw_wr); // R3

endmodule

// File: tb/gfx_ctrl_port_tb.sv
`timescale 1ns/1ps
module gfx_ctrl_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        region_pal = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        draw_wr;
    logic [31:0] draw_wdata;
    logic [1:0]  xfer_state = 2'd0;
    logic        cmd_collecting = 1'b0;
    logic        irq_raise = 1'b0;
    logic [9:0]  area_left = 10'h155, area_top = 10'h2AA;
    logic [9:0]  area_right = 10'h3F0, area_bottom = 10'h00F;
    logic [10:0] ofs_x = 11'h7FF, ofs_y = 11'h401;
    logic [19:0] tex_window = 20'hABCDE;
    logic        dma_req, queue_flush;

    always #10 clk = ~clk;

    gfx_ctrl_port u_dut (
        .clk(clk), .rst_n(rst_n), .region_pal(region_pal),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .draw_wr(draw_wr), .draw_wdata(draw_wdata),
        .xfer_state(xfer_state), .cmd_collecting(cmd_collecting),
        .irq_raise(irq_raise),
        .area_left(area_left), .area_top(area_top),
        .area_right(area_right), .area_bottom(area_bottom),
        .ofs_x(ofs_x), .ofs_y(ofs_y), .tex_window(tex_window),
        .dma_req(dma_req), .queue_flush(queue_flush)
    );

    int checks = 0;
    int failures = 0;

    // Bench model of the status fields
    logic [7:0] m_mode;
    logic       m_disp, m_irq;
    logic [1:0] m_dir;
    logic [31:0] m_latch;

    function automatic logic m_rdy_dma();
        return (xfer_state == 2'd0) || (xfer_state != 2'd2 && cmd_collecting);
    endfunction

    function automatic logic m_req();
        case (m_dir)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return m_rdy_dma();
            default: return (xfer_state == 2'd2);
        endcase
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = 32'h0000_2000;
        s[14] = m_mode[7];  s[16] = m_mode[6]; s[18:17] = m_mode[1:0];
        s[19] = m_mode[2];  s[20] = m_mode[3]; s[21] = m_mode[4];
        s[22] = m_mode[5];  s[23] = m_disp;    s[24] = m_irq;
        s[25] = m_req();    s[26] = (xfer_state == 2'd0);
        s[27] = (xfer_state == 2'd2); s[28] = m_rdy_dma();
        s[30:29] = m_dir;
        return s;
    endfunction

    // Scoreboard of expected read results
    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: a read that is not overridden by a write returns data next cycle (R2, R12)
    always @(posedge clk) rd_seen <= reg_rd && !reg_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected read result actual=%08h expected=none", reg_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(reg_rdata, e.val, e.tag);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back('{exp, tag});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] op, input logic [23:0] arg);
        wr(4'h4, {op, arg});
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_mode = 8'h00; m_disp = 1'b1; m_irq = 1'b0; m_dir = 2'd0; m_latch = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({31'd0, dma_req}, 32'd0, "R1 dma_req after reset");
        check({31'd0, queue_flush}, 32'd0, "R1 queue_flush after reset");
        rd(4'h4, 32'h1480_2000, "R1 status reset value");
        rd(4'h0, 32'h0, "R1 latch reset value");
        // R2 other offsets
        rd(4'h8, 32'hFFFF_FFFF, "R2 unmapped offset 8");
        rd(4'hC, 32'hFFFF_FFFF, "R2 unmapped offset C");

        // R3 drawing port
        wr(4'h0, 32'hA5A5_1234);
        check({31'd0, draw_wr}, 32'd1, "R3 draw_wr pulse");
        check(draw_wdata, 32'hA5A5_1234, "R3 draw_wdata");
        @(negedge clk);
        check({31'd0, draw_wr}, 32'd0, "R3 draw_wr single cycle");
        rd(4'h4, m_status(), "R3 status unchanged by draw write");

        // R7 display off flag
        ctl(8'h03, 24'hFFFFFE); m_disp = 1'b0;
        rd(4'h4, m_status(), "R7 display on via bit0=0");
        ctl(8'h03, 24'h000001); m_disp = 1'b1;
        rd(4'h4, m_status(), "R7 display off via bit0=1");

        // R9 display mode mapping
        ctl(8'h08, 24'h0000FF); m_mode = 8'hFF;
        rd(4'h4, m_status(), "R9 mode all ones");
        ctl(8'h08, 24'h00005A); m_mode = 8'h5A;
        rd(4'h4, m_status(), "R9 mode 0x5A");
        ctl(8'h08, 24'hFFFF81); m_mode = 8'h81;
        rd(4'h4, m_status(), "R9 mode 0x81 upper argument ignored");

        // R6 interrupt flag
        @(negedge clk); irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0; m_irq = 1'b1;
        rd(4'h4, m_status(), "R6 irq raised");
        ctl(8'h02, 24'h0); m_irq = 1'b0;
        rd(4'h4, m_status(), "R6 irq acknowledged");
        irq_raise = 1'b1;
        ctl(8'h02, 24'h0);
        irq_raise = 1'b0; m_irq = 1'b1;
        rd(4'h4, m_status(), "R6 raise wins over ack");
        ctl(8'h02, 24'h0); m_irq = 1'b0;

        // R8 direction with idle engine
        ctl(8'h04, 24'h1); m_dir = 2'd1;
        check({31'd0, dma_req}, 32'd1, "R8 fifo direction requests");
        ctl(8'h04, 24'h2); m_dir = 2'd2;
        check({31'd0, dma_req}, 32'd1, "R8 to-gpu idle requests");
        ctl(8'h04, 24'h3); m_dir = 2'd3;
        check({31'd0, dma_req}, 32'd0, "R8 readback idle no request");
        rd(4'h4, m_status(), "R8 status direction 3");
        ctl(8'h04, 24'h0); m_dir = 2'd0;
        check({31'd0, dma_req}, 32'd0, "R8 off direction no request");

        // R8 / R10 request follows transfer state
        ctl(8'h04, 24'h3); m_dir = 2'd3;
        xfer_state = 2'd2; settle();
        check({31'd0, dma_req}, 32'd1, "R8 readback while reading VRAM");
        rd(4'h4, m_status(), "R10 flags while reading VRAM");
        ctl(8'h04, 24'h2); m_dir = 2'd2;
        check({31'd0, dma_req}, 32'd0, "R8 to-gpu while reading VRAM");
        xfer_state = 2'd1; cmd_collecting = 1'b1; settle();
        check({31'd0, dma_req}, 32'd1, "R8 to-gpu busy collecting");
        rd(4'h4, m_status(), "R10 flags busy collecting");
        cmd_collecting = 1'b0; settle();
        check({31'd0, dma_req}, 32'd0, "R8 to-gpu busy not collecting");
        rd(4'h4, m_status(), "R10 flags busy not collecting");
        xfer_state = 2'd3; cmd_collecting = 1'b1; settle();
        rd(4'h4, m_status(), "R10 flags state 3 collecting");
        xfer_state = 2'd2; settle();
        rd(4'h4, m_status(), "R10 collecting ignored while reading VRAM");
        xfer_state = 2'd0; cmd_collecting = 1'b0; settle();
        rd(4'h4, m_status(), "R10 flags back to idle");

        // R11 info queries
        ctl(8'h10, 24'h000003); m_latch = {12'd0, area_top, area_left};
        rd(4'h0, m_latch, "R11 sub3 area top-left");
        ctl(8'h1F, 24'h000004); m_latch = {12'd0, area_bottom, area_right};
        rd(4'h0, m_latch, "R11 sub4 area bottom-right");
        ctl(8'h15, 24'hFFFF05); m_latch = {10'd0, ofs_y, ofs_x};
        rd(4'h0, m_latch, "R11 sub5 offsets");
        ctl(8'h12, 24'h000002); m_latch = {12'd0, tex_window};
        rd(4'h0, m_latch, "R11 sub2 texture window");
        ctl(8'h11, 24'h000000);
        ctl(8'h10, 24'h000001);
        ctl(8'h1A, 24'h000006);
        ctl(8'h13, 24'h000007);
        rd(4'h0, m_latch, "R11 sub0/1/6/7 keep latch");

        // R13 unlisted opcodes
        ctl(8'h09, 24'hFFFFFF);
        check({31'd0, queue_flush}, 32'd0, "R13 no flush for opcode 09");
        ctl(8'h20, 24'h000003);
        ctl(8'h05, 24'h000004);
        ctl(8'hFF, 24'hFFFFFF);
        rd(4'h4, m_status(), "R13 status unchanged");
        rd(4'h0, m_latch, "R13 latch unchanged");

        // R5 queue flush
        ctl(8'h01, 24'h0);
        check({31'd0, queue_flush}, 32'd1, "R5 flush pulse");
        @(negedge clk);
        check({31'd0, queue_flush}, 32'd0, "R5 flush single cycle");
        rd(4'h4, m_status(), "R5 status unchanged");

        // R12 write wins over read
        rd(4'h0, m_latch, "R12 reference read");
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 4'h4; reg_wdata = {8'h03, 24'h000000};
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; m_disp = 1'b0;
        check(reg_rdata, m_latch, "R12 rdata held on collision");
        rd(4'h4, m_status(), "R12 colliding write applied");

        // R4 soft reset
        ctl(8'h04, 24'h1); m_dir = 2'd1;
        ctl(8'h08, 24'h0000F7); m_mode = 8'hF7;
        region_pal = 1'b1;
        ctl(8'h00, 24'h0);
        m_mode = 8'h08; m_disp = 1'b1; m_irq = 1'b0; m_dir = 2'd0;
        check({31'd0, queue_flush}, 32'd1, "R4 flush on soft reset");
        check({31'd0, dma_req}, 32'd0, "R4 request dropped");
        rd(4'h4, 32'h1490_2000, "R4 status reset with PAL");
        rd(4'h0, m_latch, "R4 latch kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule